// File: doc/BRIEF.md
# Low-Voltage Reset Controller

This block is the digital side of a supply-voltage monitor. The analog front end has two pairs of comparators. One pair serves a low-supply (3 V) mode and the other a high-supply (5 V) mode. In each pair, one comparator reports that the supply has dropped under the falling threshold and the other reports that it has climbed over the rising threshold. The controller resynchronises these four signals and picks the pair that belongs to the selected mode. From that it raises a registered reset request that stays latched, with hysteresis, until the rising comparator of that mode reports recovery.

A four-bit control register is loaded through a one-cycle write strobe. Its bits switch monitoring off, block the reset request, keep monitoring alive in stop mode and select the high-supply mode. An active-high, asynchronous power-on reset returns every control bit to its default and drops any held request. After each power-on reset the block is always back in low-supply mode, so software must select the high-supply mode again every time. All pins are plain control and status signals. No data stream passes through the block, so there is no handshake.

Top module: `lvr_ctrl`

## Requirements
- R1: While `por` is high, and after it falls, `lv_reset`, `trip_flag` and `mode_hi` are 0 and all control bits hold their defaults: monitoring on, reset allowed, stop-keep off, low-supply mode.
- R2: A clock edge with `wr_en` high loads `wr_data` into the control register: bit 0 switches monitoring off, bit 1 blocks the reset request, bit 2 keeps monitoring alive in stop mode, bit 3 selects the high-supply mode. `mode_hi` shows bit 3 from the following cycle.
- R3: `trip_flag` equals the synchronised falling comparator of the selected mode while monitoring is active, and is 0 otherwise. Monitoring is active when bit 0 is clear and either `stop_mode` is low or bit 2 is set.
- R4: Each comparator input passes through a two-flop synchroniser. A change reaches `trip_flag` after two rising edges and `lv_reset` after three.
- R5: `lv_reset` rises one edge after monitoring is active, bit 1 is clear and the synchronised falling comparator of the selected mode is high.
- R6: While bit 0 or bit 1 is set, a low supply does not raise `lv_reset`.
- R7: In stop mode with bit 2 clear, a low supply does not raise `lv_reset`. With bit 2 set, it does.
- R8: Once `lv_reset` is high, it stays high until the synchronised rising comparator of the selected mode is high, even after the falling comparator clears. It then falls on the next edge. The comparators of the other mode have no effect.
- R9: Selecting the high-supply mode while the high-supply falling comparator is already synchronised high raises `lv_reset` one edge after `mode_hi` rises.
- R10: A power-on reset during a held request clears `lv_reset` and returns `mode_hi` to 0. A high-supply falling comparator then no longer causes a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| stop_mode | input | 1 | Chip is in stop mode |
| lo_fall | input | 1 | Supply under the low-supply falling threshold |
| lo_rise | input | 1 | Supply over the low-supply rising threshold |
| hi_fall | input | 1 | Supply under the high-supply falling threshold |
| hi_rise | input | 1 | Supply over the high-supply rising threshold |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Control register write value |
| trip_flag | output | 1 | Selected falling comparator, gated by monitoring |
| lv_reset | output | 1 | Held low-voltage reset request |
| mode_hi | output | 1 | High-supply mode selected |

## Verification
On every cycle the assertions check the following. Each synchroniser stage copies the stage before it. A write lands in the control register. `trip_flag` is never high while monitoring is switched off. A held request never drops unless the selected rising comparator is high. A request never rises without an armed cause. The bench scenarios cover what needs a sequence of events: the exact three-edge latency from a comparator to `lv_reset`, hysteresis once the falling comparator clears, the stop-mode gating, mode selection asserting reset at once, and a power-on reset cancelling a held request and the high-supply mode together.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  // Control register layout, MSB first: bit3 hi mode, bit2 stop keep,
  // bit1 reset block, bit0 monitor off.
  typedef struct packed {
    logic mode_hi;
    logic stop_keep;
    logic rst_off;
    logic pwr_off;
  } lvr_cfg_t;

  localparam int CFG_W = $bits(lvr_cfg_t);
  localparam lvr_cfg_t CFG_DEFAULT = '0;

  // Comparator vector indices
  localparam int CMP_LO_FALL = 0;
  localparam int CMP_LO_RISE = 1;
  localparam int CMP_HI_FALL = 2;
  localparam int CMP_HI_RISE = 3;
  localparam int CMP_W       = 4;
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge por) begin
          if (por) stage_q[0] <= '0;
          else     stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge por) begin
          if (por) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
        // R4
        stage_shift_chk: assert property (@(posedge clk) disable iff (por)
          stage_q[g] == $past(stage_q[g-1]));
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/lvr_cfg_reg.sv
module lvr_cfg_reg
  import lvr_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output lvr_cfg_t         cfg_q
);
  always_ff @(posedge clk or posedge por) begin
    if (por)        cfg_q <= CFG_DEFAULT;
    else if (wr_en) cfg_q <= lvr_cfg_t'(wr_data);
  end

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (por)
    wr_en |=> (cfg_q == lvr_cfg_t'($past(wr_data))));
endmodule

// File: rtl/lvr_hold.sv
module lvr_hold (
  input  logic clk,
  input  logic por,
  input  logic arm,
  input  logic below,
  input  logic above,
  output logic hold_q
);
  logic hold_d;

  always_comb begin
    if (hold_q) hold_d = !above;
    else        hold_d = arm && below;
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) hold_q <= 1'b0;
    else     hold_q <= hold_d;
  end

  // R8
  held_keep_chk: assert property (@(posedge clk) disable iff (por)
    (hold_q && !above) |=> hold_q);
  // R5
  set_cause_chk: assert property (@(posedge clk) disable iff (por)
    $rose(hold_q) |-> $past(arm && below));
endmodule

// File: rtl/lvr_ctrl.sv
module lvr_ctrl
  import lvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic             stop_mode,
  input  logic             lo_fall,
  input  logic             lo_rise,
  input  logic             hi_fall,
  input  logic             hi_rise,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic             trip_flag,
  output logic             lv_reset,
  output logic             mode_hi
);
  logic [CMP_W-1:0] cmp_raw, cmp_s;
  lvr_cfg_t         cfg;
  logic             active, below, above;

  assign cmp_raw[CMP_LO_FALL] = lo_fall;
  assign cmp_raw[CMP_LO_RISE] = lo_rise;
  assign cmp_raw[CMP_HI_FALL] = hi_fall;
  assign cmp_raw[CMP_HI_RISE] = hi_rise;

  lvr_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por(por), .d_in(cmp_raw), .d_out(cmp_s));

  lvr_cfg_reg u_cfg (
    .clk(clk), .por(por), .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg));

  assign active = !cfg.pwr_off && (!stop_mode || cfg.stop_keep);
  assign below  = cfg.mode_hi ? cmp_s[CMP_HI_FALL] : cmp_s[CMP_LO_FALL];
  assign above  = cfg.mode_hi ? cmp_s[CMP_HI_RISE] : cmp_s[CMP_LO_RISE];

  lvr_hold u_hold (
    .clk(clk), .por(por), .arm(active && !cfg.rst_off),
    .below(below), .above(above), .hold_q(lv_reset));

  assign trip_flag = active && below;
  assign mode_hi   = cfg.mode_hi;

  // R3
  trip_gate_chk: assert property (@(posedge clk) disable iff (por)
    trip_flag |-> !cfg.pwr_off);
endmodule

// File: tb/lvr_ctrl_tb.sv
module lvr_ctrl_tb;
  logic clk = 1'b0;
  logic por = 1'b1;
  logic stop_mode = 1'b0;
  logic lo_fall = 1'b0, lo_rise = 1'b0, hi_fall = 1'b0, hi_rise = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic trip_flag, lv_reset, mode_hi;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lvr_ctrl u_dut (
    .clk(clk), .por(por), .stop_mode(stop_mode),
    .lo_fall(lo_fall), .lo_rise(lo_rise), .hi_fall(hi_fall), .hi_rise(hi_rise),
    .wr_en(wr_en), .wr_data(wr_data),
    .trip_flag(trip_flag), .lv_reset(lv_reset), .mode_hi(mode_hi));

  // Behavioural reference: control word, comparator delay queue, held flag
  logic [3:0] m_cfg = 4'h0;
  logic [3:0] m_pipe [$] = '{4'h0, 4'h0};
  bit         m_lv = 0;

  function automatic bit m_act();
    return !m_cfg[0] && (!stop_mode || m_cfg[2]);
  endfunction
  function automatic bit m_below();
    return m_cfg[3] ? m_pipe[0][2] : m_pipe[0][0];
  endfunction
  function automatic bit m_above();
    return m_cfg[3] ? m_pipe[0][3] : m_pipe[0][1];
  endfunction

  always @(posedge clk) begin
    if (por) begin
      m_cfg = 4'h0; m_lv = 0;
      m_pipe = '{4'h0, 4'h0};
    end else begin
      if (m_lv) m_lv = !m_above();
      else      m_lv = m_act() && !m_cfg[1] && m_below();
      if (wr_en) m_cfg = wr_data;
      void'(m_pipe.pop_front());
      m_pipe.push_back({hi_rise, hi_fall, lo_rise, lo_fall});
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!por && !done) begin
      check("R5", "model lv_reset", lv_reset, m_lv);
      check("R3", "model trip_flag", trip_flag, m_act() && m_below());
      check("R2", "model mode_hi", mode_hi, m_cfg[3]);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_cfg(logic [3:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0;
  endtask

  initial begin
    step(3);
    // R1 reset state while por is high
    check("R1", "lv_reset in por", lv_reset, 1'b0);
    check("R1", "mode_hi in por", mode_hi, 1'b0);
    por = 1'b0;
    step(2);
    check("R1", "trip_flag after por", trip_flag, 1'b0);

    // R4 and R5: low-supply falling comparator
    lo_fall = 1'b1;
    step(2);
    check("R4", "trip after two edges", trip_flag, 1'b1);
    check("R4", "lv_reset not yet", lv_reset, 1'b0);
    step(1);
    check("R5", "lv_reset after three edges", lv_reset, 1'b1);

    // R8 hysteresis
    lo_fall = 1'b0;
    step(5);
    check("R8", "held after fall clears", lv_reset, 1'b1);
    hi_rise = 1'b1;
    step(4);
    check("R8", "other-mode rise ignored", lv_reset, 1'b1);
    hi_rise = 1'b0; lo_rise = 1'b1;
    step(4);
    check("R8", "released by rise", lv_reset, 1'b0);
    lo_rise = 1'b0;

    // R6 gating by monitor off and reset block
    write_cfg(4'b0001);
    lo_fall = 1'b1;
    step(5);
    check("R6", "monitor off no reset", lv_reset, 1'b0);
    check("R3", "monitor off trip 0", trip_flag, 1'b0);
    write_cfg(4'b0010);
    step(3);
    check("R6", "reset blocked", lv_reset, 1'b0);
    check("R3", "trip visible when blocked", trip_flag, 1'b1);
    write_cfg(4'b0000);
    step(2);
    check("R5", "unblocked asserts", lv_reset, 1'b1);
    lo_fall = 1'b0; lo_rise = 1'b1;
    step(4);
    lo_rise = 1'b0;

    // R7 stop mode
    stop_mode = 1'b1; lo_fall = 1'b1;
    step(5);
    check("R7", "stopped no reset", lv_reset, 1'b0);
    check("R7", "stopped trip 0", trip_flag, 1'b0);
    write_cfg(4'b0100);
    step(2);
    check("R7", "stop keep asserts", lv_reset, 1'b1);
    stop_mode = 1'b0; lo_fall = 1'b0; lo_rise = 1'b1;
    step(4);
    lo_rise = 1'b0;
    write_cfg(4'b0000);
    step(3);

    // R9 mode selection while high-supply falling is high
    hi_fall = 1'b1;
    step(4);
    check("R9", "low mode ignores hi_fall", lv_reset, 1'b0);
    write_cfg(4'b1000);
    check("R2", "mode_hi after write", mode_hi, 1'b1);
    check("R9", "lv_reset not before mode", lv_reset, 1'b0);
    step(1);
    check("R9", "lv_reset one edge later", lv_reset, 1'b1);

    // R10 power-on reset during held request
    por = 1'b1;
    step(1);
    check("R10", "por clears lv_reset", lv_reset, 1'b0);
    check("R10", "por restores low mode", mode_hi, 1'b0);
    por = 1'b0;
    step(5);
    check("R10", "hi_fall ignored after por", lv_reset, 1'b0);

    // R8 in high mode: low rise has no effect, high rise releases
    write_cfg(4'b1000);
    step(2);
    check("R9", "hi mode asserts again", lv_reset, 1'b1);
    hi_fall = 1'b0; lo_rise = 1'b1;
    step(4);
    check("R8", "lo_rise ignored in hi mode", lv_reset, 1'b1);
    hi_rise = 1'b1;
    step(4);
    check("R8", "hi_rise releases", lv_reset, 1'b0);
    hi_rise = 1'b0; lo_rise = 1'b0;
    step(4);
    finish_run();
  end
endmodule